// File: doc/BRIEF.md
# GPIO Line Interrupt Detector

This block watches three 8-bit groups of general-purpose input pins (called ports A, B and F) and turns level conditions or edges on them into interrupt requests. Software configures it through byte-wide registers on a simple memory-mapped write/read bus. For each line it selects whether the line responds to a level or to an edge, and which polarity. It also sets whether the line may raise an interrupt at all, and whether its input is debounced first. Every pin passes through a two-flop synchroniser and an optional stability filter before detection.

Edge events are held in a per-line latch until software acknowledges them by writing a one to that line's bit in an acknowledge register. Level requests are not stored: they follow the qualified input. Ports A and B share one interrupt output. Port F drives one output per line. Ports A and B also expose a read-only byte that shows which of their lines have a request pending.

Top module: `gpio_irq_top`

## Requirements
- R1: After a synchronous active-low reset every configuration register, every edge latch and every pending bit is 0, so both interrupt outputs are low and every mapped register reads 0.
- R2: Register byte addresses are as follows. Port A: kind 0x90, polarity 0x94, acknowledge 0x98, enable 0x9C, debounce 0xA8, pending 0xA0. Port B: kind 0xAC, polarity 0xB0, acknowledge 0xB4, enable 0xB8, debounce 0xC4, pending 0xBC. Port F: kind 0x4C, polarity 0x50, acknowledge 0x54, enable 0x58, debounce 0x64. Kind, polarity, enable and debounce read back what was written. Acknowledge reads 0. Writes to unmapped addresses change nothing and unmapped reads return 0. Line n is bit n of every register.
- R3: A kind bit of 0 makes the line level-sensitive and 1 makes it edge-sensitive. A polarity bit of 0 selects low level or falling edge, and 1 selects high level or rising edge.
- R4: A qualifying edge sets the line's latch, which stays set after the input returns. Writing the acknowledge register clears the latch of every line whose written bit is 1 and leaves lines written 0 untouched. A new edge in the same cycle as its acknowledge remains latched.
- R5: A level-sensitive line is pending exactly while its qualified input matches the selected level. It is never latched, and acknowledge writes do not affect it.
- R6: A line is pending only while its enable bit is 1. An edge that arrived while the line was disabled becomes pending as soon as the line is enabled.
- R7: A write to the kind or polarity register clears the edge latch of every line whose bit in that register changes. Other lines keep their latches.
- R8: With debounce off, a pin change is reflected in a level-sensitive pending bit after exactly two rising clock edges and not after one.
- R9: With a debounce bit set, the filtered input takes a new value only after the synchronised pin has differed from it for DEB_STABLE consecutive sample ticks, spaced DEB_DIV clocks apart (defaults 4 and 4). Shorter pulses are ignored.
- R10: irq_ab is the OR of all pending bits of ports A and B. irq_f[n] is the pending bit of port F line n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wr_en | input | 1 | Write strobe, one write per cycle high |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| pin_a | input | 8 | Port A pins, asynchronous |
| pin_b | input | 8 | Port B pins, asynchronous |
| pin_f | input | 8 | Port F pins, asynchronous |
| irq_ab | output | 1 | Combined request of ports A and B |
| irq_f | output | 8 | Per-line requests of port F |

## Verification
The bench checks the first cycle in which a level request appears. A design with an extra or missing synchroniser stage would be off by one edge there. It acknowledges with a mix of one and zero bits, so a design that clears every latch on any acknowledge write is caught. The bench also reprograms the polarity of one latched line next to another latched line that keeps its setting. A design that clears too much, or leaves a stale edge set, fails that check. Debounce is checked with a pulse shorter than the stability window and with a long hold, and a filter that counts ticks wrongly would pass the pulse or block the hold. Randomised configurations and pin patterns then compare every pending bit against a model of level and edge detection.

// File: rtl/gpio_irq_pkg.sv
// Shared constants and the register map type for the GPIO interrupt detector.
// Assumes byte-wide registers and an 8-bit byte address.
package gpio_irq_pkg;

    localparam int NUM_PORTS = 3;
    localparam int ADDR_W    = 8;

    // Byte addresses of one port's registers.
    typedef struct packed {
        logic [ADDR_W-1:0] kind;
        logic [ADDR_W-1:0] pol;
        logic [ADDR_W-1:0] ack;
        logic [ADDR_W-1:0] en;
        logic [ADDR_W-1:0] deb;
        logic [ADDR_W-1:0] pend;
        logic              has_pend;
    } port_map_t;

    // Address map per port index: 0 = A, 1 = B, 2 = F.
    function automatic port_map_t map_of(input int idx);
        port_map_t m;
        case (idx)
            0: m = '{kind: 8'h90, pol: 8'h94, ack: 8'h98, en: 8'h9C,
                     deb: 8'hA8, pend: 8'hA0, has_pend: 1'b1};
            1: m = '{kind: 8'hAC, pol: 8'hB0, ack: 8'hB4, en: 8'hB8,
                     deb: 8'hC4, pend: 8'hBC, has_pend: 1'b1};
            default: m = '{kind: 8'h4C, pol: 8'h50, ack: 8'h54, en: 8'h58,
                     deb: 8'h64, pend: 8'h00, has_pend: 1'b0};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gpio_irq_filter.sv
// One input line: two-flop synchroniser followed by an optional stability
// filter. Assumes tick is a single-cycle pulse from a shared divider.
// Output q is the synchronised value when deb_en is 0, else the filtered one.
module gpio_irq_filter #(
    parameter int DEB_STABLE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic deb_en,
    input  logic tick,
    output logic q
);
    localparam int CNT_W = (DEB_STABLE > 1) ? $clog2(DEB_STABLE) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DEB_STABLE - 1);

    logic             meta;
    logic             sync;
    logic             filt;
    logic [CNT_W-1:0] cnt;

    // Bring the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= 1'b0;
            sync <= 1'b0;
        end else begin
            meta <= pin;
            sync <= meta;
        end
    end

    // Accept a new value only after DEB_STABLE ticks of continuous difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt <= 1'b0;
            cnt  <= '0;
        end else if (!deb_en || sync == filt) begin
            filt <= sync;
            cnt  <= '0;
        end else if (tick) begin
            if (cnt == LAST) begin
                filt <= sync;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Select the qualified input.
    always_comb q = deb_en ? filt : sync;

    // R9: the filtered value must not move before the tick count completes.
    assert_hold_until_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (deb_en && sync != filt && !(tick && cnt == LAST)) |=> $stable(filt));

endmodule

// File: rtl/gpio_irq_port.sv
// One 8-line port: configuration registers, per-line input qualification,
// level and edge detection, edge latches and the pending vector.
// Assumes the bus delivers at most one write per cycle.
module gpio_irq_port #(
    parameter int                     LINES      = 8,
    parameter int                     DEB_STABLE = 4,
    parameter gpio_irq_pkg::port_map_t MAP       = gpio_irq_pkg::map_of(0)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [gpio_irq_pkg::ADDR_W-1:0] addr,
    input  logic [LINES-1:0]                wdata,
    input  logic                            tick,
    input  logic [LINES-1:0]                pins,
    output logic [LINES-1:0]                rd_data,
    output logic [LINES-1:0]                pending
);
    logic [LINES-1:0] kind;
    logic [LINES-1:0] pol;
    logic [LINES-1:0] en_r;
    logic [LINES-1:0] deb;
    logic [LINES-1:0] q;
    logic [LINES-1:0] q_d;
    logic [LINES-1:0] latch;
    logic [LINES-1:0] edge_evt;
    logic [LINES-1:0] level_hit;
    logic [LINES-1:0] clr_ack;
    logic [LINES-1:0] clr_type;
    logic             wr_kind, wr_pol, wr_ack, wr_en_r, wr_deb;

    // Decode write strobes for this port.
    always_comb begin
        wr_kind = wr_en && (addr == MAP.kind);
        wr_pol  = wr_en && (addr == MAP.pol);
        wr_ack  = wr_en && (addr == MAP.ack);
        wr_en_r = wr_en && (addr == MAP.en);
        wr_deb  = wr_en && (addr == MAP.deb);
    end

    // Hold the configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind <= '0;
            pol  <= '0;
            en_r <= '0;
            deb  <= '0;
        end else begin
            if (wr_kind) kind <= wdata;
            if (wr_pol)  pol  <= wdata;
            if (wr_en_r) en_r <= wdata;
            if (wr_deb)  deb  <= wdata;
        end
    end

    // Qualify every line through its own synchroniser and filter.
    for (genvar i = 0; i < LINES; i++) begin : g_line
        gpio_irq_filter #(.DEB_STABLE(DEB_STABLE)) filt_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (pins[i]),
            .deb_en (deb[i]),
            .tick   (tick),
            .q      (q[i])
        );
    end

    // Remember the previous qualified input for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) q_d <= '0;
        else        q_d <= q;
    end

    // Detect edges, levels and the latch clear sources.
    always_comb begin
        edge_evt  = kind & ((pol & q & ~q_d) | (~pol & ~q & q_d));
        level_hit = ~kind & ~(pol ^ q);
        clr_ack   = wr_ack ? wdata : '0;
        if (wr_kind)     clr_type = kind ^ wdata;
        else if (wr_pol) clr_type = pol ^ wdata;
        else             clr_type = '0;
    end

    // Latch edges; a new edge beats an acknowledge, a type change beats both.
    always_ff @(posedge clk) begin
        if (!rst_n) latch <= '0;
        else        latch <= ((latch & ~clr_ack) | edge_evt) & ~clr_type;
    end

    // Combine latched edges and live levels under the enable mask.
    always_comb pending = en_r & ((kind & latch) | level_hit);

    // Return the addressed register, zero when not mapped here.
    always_comb begin
        if (addr == MAP.kind)                   rd_data = kind;
        else if (addr == MAP.pol)               rd_data = pol;
        else if (addr == MAP.en)                rd_data = en_r;
        else if (addr == MAP.deb)               rd_data = deb;
        else if (MAP.has_pend && addr == MAP.pend) rd_data = pending;
        else                                    rd_data = '0;
    end

    // R4: an acknowledged line without a fresh edge is clear afterwards.
    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> ((latch & $past(wdata & ~edge_evt)) == '0));

    // R4: a detected edge is held unless the type registers are written.
    assert_edge_captured_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_evt && !wr_kind && !wr_pol) |=> ((latch & $past(edge_evt)) == $past(edge_evt)));

    // R5: level-sensitive lines never carry a latched edge.
    assert_level_unlatched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (latch & ~kind) == '0);

    // R7: a line whose type bit changed has no latched edge afterwards.
    assert_type_change_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_kind |=> ((latch & $past(kind ^ wdata)) == '0));

endmodule

// File: rtl/gpio_irq_top.sv
// GPIO interrupt detector for three ports: shared debounce tick divider,
// three port instances, read-data merge and interrupt output combining.
// Assumes pins are asynchronous and the bus is synchronous to clk.
module gpio_irq_top #(
    parameter int LINES      = 8,
    parameter int DEB_DIV    = 4,
    parameter int DEB_STABLE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       reg_addr,
    input  logic             reg_wr_en,
    input  logic [LINES-1:0] reg_wdata,
    output logic [LINES-1:0] reg_rdata,
    input  logic [LINES-1:0] pin_a,
    input  logic [LINES-1:0] pin_b,
    input  logic [LINES-1:0] pin_f,
    output logic             irq_ab,
    output logic [LINES-1:0] irq_f
);
    import gpio_irq_pkg::*;

    localparam int DIV_W = (DEB_DIV > 1) ? $clog2(DEB_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(DEB_DIV - 1);

    logic [DIV_W-1:0]                  div_cnt;
    logic                              tick;
    logic [NUM_PORTS-1:0][LINES-1:0]   pins_all;
    logic [NUM_PORTS-1:0][LINES-1:0]   rd_all;
    logic [NUM_PORTS-1:0][LINES-1:0]   pend_all;

    // Free-running divider that paces the debounce samples.
    always_ff @(posedge clk) begin
        if (!rst_n)              div_cnt <= '0;
        else if (div_cnt == DIV_LAST) div_cnt <= '0;
        else                     div_cnt <= div_cnt + 1'b1;
    end

    // Mark the last cycle of each divider period.
    always_comb tick = (div_cnt == DIV_LAST);

    // Gather pins into port order A, B, F.
    always_comb pins_all = {pin_f, pin_b, pin_a};

    // One detector per port, each with its own address map.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gpio_irq_port #(
            .LINES      (LINES),
            .DEB_STABLE (DEB_STABLE),
            .MAP        (map_of(p))
        ) port_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (reg_wr_en),
            .addr    (reg_addr),
            .wdata   (reg_wdata),
            .tick    (tick),
            .pins    (pins_all[p]),
            .rd_data (rd_all[p]),
            .pending (pend_all[p])
        );
    end

    // Merge read data; unmapped addresses yield zero from every port.
    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) reg_rdata = reg_rdata | rd_all[p];
    end

    // Drive the shared A/B request and the per-line F requests.
    always_comb begin
        irq_ab = (|pend_all[0]) | (|pend_all[1]);
        irq_f  = pend_all[2];
    end

    // R10: the shared request is low whenever both A and B are quiet.
    assert_ab_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_all[0] == '0 && pend_all[1] == '0) |-> !irq_ab);

endmodule

// File: tb/gpio_irq_top_tb_top.sv
// Self-checking bench: directed corner cases, then seeded random configurations.
module gpio_irq_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pin_a = '0;
    logic [7:0] pin_b = '0;
    logic [7:0] pin_f = '0;
    logic       irq_ab;
    logic [7:0] irq_f;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpio_irq_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_a(pin_a),
        .pin_b(pin_b), .pin_f(pin_f), .irq_ab(irq_ab), .irq_f(irq_f)
    );

    function automatic logic [7:0] a_kind(int i); return i == 0 ? 8'h90 : i == 1 ? 8'hAC : 8'h4C; endfunction
    function automatic logic [7:0] a_pol(int i);  return i == 0 ? 8'h94 : i == 1 ? 8'hB0 : 8'h50; endfunction
    function automatic logic [7:0] a_ack(int i);  return i == 0 ? 8'h98 : i == 1 ? 8'hB4 : 8'h54; endfunction
    function automatic logic [7:0] a_en(int i);   return i == 0 ? 8'h9C : i == 1 ? 8'hB8 : 8'h58; endfunction
    function automatic logic [7:0] a_deb(int i);  return i == 0 ? 8'hA8 : i == 1 ? 8'hC4 : 8'h64; endfunction
    function automatic logic [7:0] a_pend(int i); return i == 0 ? 8'hA0 : 8'hBC; endfunction

    function automatic logic [7:0] exp_level(logic [7:0] k, logic [7:0] pl, logic [7:0] e, logic [7:0] p);
        return e & ~k & ~(pl ^ p);
    endfunction

    function automatic logic [7:0] exp_edge(logic [7:0] k, logic [7:0] pl, logic [7:0] e,
                                            logic [7:0] p0, logic [7:0] p1);
        return e & k & ((pl & p1 & ~p0) | (~pl & ~p1 & p0));
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pins(int i, logic [7:0] v);
        @(negedge clk);
        if (i == 0) pin_a = v; else if (i == 1) pin_b = v; else pin_f = v;
    endtask

    task automatic pend_of(int i, output logic [7:0] d);
        if (i == 2) begin @(negedge clk); #1 d = irq_f; end
        else rd(a_pend(i), d);
    endtask

    task automatic setup(int i, logic [7:0] k, logic [7:0] pl, logic [7:0] e, logic [7:0] d);
        wr(a_en(i), 8'h00);
        wr(a_kind(i), k);
        wr(a_pol(i), pl);
        wr(a_deb(i), d);
        wr(a_en(i), e);
    endtask

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %h expected %h", 8'h00, 8'h01);
            report();
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] r_k [3];
        logic [7:0] r_p [3];
        logic [7:0] r_e [3];
        logic [7:0] p0  [3];
        logic [7:0] p1  [3];
        logic [7:0] ex  [3];
        int unused_seed;
        unused_seed = $urandom(32'h5EED_0417);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(8'hA0, v); chk("R1 pend A", v, 8'h00);
        rd(8'hBC, v); chk("R1 pend B", v, 8'h00);
        rd(8'h90, v); chk("R1 kind A", v, 8'h00);
        rd(8'h58, v); chk("R1 en F", v, 8'h00);
        rd(8'hC4, v); chk("R1 deb B", v, 8'h00);
        chk("R1 irq_ab", {7'b0, irq_ab}, 8'h00);
        chk("R1 irq_f", irq_f, 8'h00);

        // R2: readback, acknowledge reads 0, unmapped write ignored
        wr(8'h90, 8'h11); wr(8'h94, 8'h22); wr(8'hA8, 8'h33); wr(8'h50, 8'h44);
        wr(8'h00, 8'hFF); wr(8'hA4, 8'hFF);
        rd(8'h90, v); chk("R2 kind A", v, 8'h11);
        rd(8'h94, v); chk("R2 pol A", v, 8'h22);
        rd(8'hA8, v); chk("R2 deb A", v, 8'h33);
        rd(8'h50, v); chk("R2 pol F", v, 8'h44);
        rd(8'h98, v); chk("R2 ack reads 0", v, 8'h00);
        rd(8'h00, v); chk("R2 unmapped 00", v, 8'h00);
        rd(8'hA4, v); chk("R2 unmapped A4", v, 8'h00);
        wr(8'h90, 8'h00); wr(8'h94, 8'h00); wr(8'hA8, 8'h00); wr(8'h50, 8'h00);

        // R8: level-high line 0 of A, exact synchroniser latency
        setup(0, 8'h00, 8'h01, 8'h01, 8'h00);
        @(negedge clk); reg_addr = 8'hA0;
        @(negedge clk); pin_a = 8'h01;
        @(posedge clk); #1 chk("R8 after one edge", reg_rdata, 8'h00);
        @(posedge clk); #1 chk("R8 after two edges", reg_rdata, 8'h01);
        set_pins(0, 8'h00); wait_clk(4);
        rd(8'hA0, v); chk("R8 level drops", v, 8'h00);

        // R3/R4: rising edge latched, selective acknowledge
        setup(0, 8'h02, 8'h02, 8'h02, 8'h00);
        set_pins(0, 8'h02); wait_clk(3); set_pins(0, 8'h00); wait_clk(5);
        rd(8'hA0, v); chk("R4 edge held after return", v, 8'h02);
        wr(8'h98, 8'hFD); wait_clk(1);
        rd(8'hA0, v); chk("R4 zero bit keeps latch", v, 8'h02);
        wr(8'h98, 8'h02); wait_clk(1);
        rd(8'hA0, v); chk("R4 ack clears", v, 8'h00);
        wr(8'h94, 8'h00);
        set_pins(0, 8'h02); wait_clk(5);
        rd(8'hA0, v); chk("R3 rising ignored when falling", v, 8'h00);
        set_pins(0, 8'h00); wait_clk(5);
        rd(8'hA0, v); chk("R3 falling edge latched", v, 8'h02);
        wr(8'h98, 8'h02);

        // R5: level-low line 2, acknowledge has no effect
        setup(0, 8'h00, 8'h00, 8'h04, 8'h00);
        wait_clk(3);
        rd(8'hA0, v); chk("R5 low level pending", v, 8'h04);
        wr(8'h98, 8'hFF); wait_clk(1);
        rd(8'hA0, v); chk("R5 ack ignored by level", v, 8'h04);
        set_pins(0, 8'h04); wait_clk(4);
        rd(8'hA0, v); chk("R5 level follows pin", v, 8'h00);
        set_pins(0, 8'h00);

        // R6: edge while disabled appears on enable
        setup(0, 8'h08, 8'h08, 8'h00, 8'h00);
        set_pins(0, 8'h08); wait_clk(5);
        rd(8'hA0, v); chk("R6 masked while disabled", v, 8'h00);
        chk("R6 irq_ab masked", {7'b0, irq_ab}, 8'h00);
        wr(8'h9C, 8'h08);
        rd(8'hA0, v); chk("R6 shows after enable", v, 8'h08);
        wr(8'h98, 8'h08); set_pins(0, 8'h00); wait_clk(4);

        // R7: polarity change on line 4 clears only line 4
        setup(0, 8'h30, 8'h30, 8'h30, 8'h00);
        set_pins(0, 8'h30); wait_clk(5);
        rd(8'hA0, v); chk("R7 both latched", v, 8'h30);
        wr(8'h94, 8'h20);
        rd(8'hA0, v); chk("R7 changed line cleared", v, 8'h20);
        wr(8'h98, 8'hFF); set_pins(0, 8'h00); wait_clk(4);
        wr(8'h98, 8'hFF);
        wr(8'h9C, 8'h00);

        // R9: debounce on B line 0, rising edge
        setup(1, 8'h01, 8'h01, 8'h01, 8'h01);
        set_pins(1, 8'h01); wait_clk(8); set_pins(1, 8'h00); wait_clk(30);
        rd(8'hBC, v); chk("R9 short pulse ignored", v, 8'h00);
        set_pins(1, 8'h01); wait_clk(10);
        rd(8'hBC, v); chk("R9 not yet accepted", v, 8'h00);
        wait_clk(20);
        rd(8'hBC, v); chk("R9 held input accepted", v, 8'h01);
        chk("R10 irq_ab from B", {7'b0, irq_ab}, 8'h01);
        wr(8'hB4, 8'h01); wait_clk(1);
        chk("R10 irq_ab cleared", {7'b0, irq_ab}, 8'h00);
        set_pins(1, 8'h00); wait_clk(30);
        wr(8'hB8, 8'h00); wr(8'hC4, 8'h00);

        // R10: port F per-line outputs, A/B shared output
        setup(2, 8'h00, 8'h40, 8'h40, 8'h00);
        set_pins(2, 8'h40); wait_clk(4);
        chk("R10 irq_f line 6", irq_f, 8'h40);
        chk("R10 irq_ab unaffected by F", {7'b0, irq_ab}, 8'h00);
        setup(0, 8'h00, 8'h80, 8'h80, 8'h00);
        set_pins(0, 8'h80); wait_clk(4);
        chk("R10 irq_ab from A", {7'b0, irq_ab}, 8'h01);
        chk("R10 irq_f unchanged", irq_f, 8'h40);

        // R3/R4/R5/R6: random configurations and pin patterns
        for (int it = 0; it < 20; it++) begin
            for (int i = 0; i < 3; i++) begin
                r_k[i] = 8'($urandom); r_p[i] = 8'($urandom); r_e[i] = 8'($urandom);
                p0[i] = 8'($urandom); p1[i] = 8'($urandom);
                setup(i, r_k[i], r_p[i], r_e[i], 8'h00);
                set_pins(i, p0[i]);
            end
            wait_clk(6);
            for (int i = 0; i < 3; i++) wr(a_ack(i), 8'hFF);
            wait_clk(2);
            for (int i = 0; i < 3; i++) begin
                pend_of(i, v);
                chk("R5 random level", v, exp_level(r_k[i], r_p[i], r_e[i], p0[i]));
            end
            for (int i = 0; i < 3; i++) set_pins(i, p1[i]);
            wait_clk(6);
            for (int i = 0; i < 3; i++) begin
                ex[i] = exp_level(r_k[i], r_p[i], r_e[i], p1[i]) |
                        exp_edge(r_k[i], r_p[i], r_e[i], p0[i], p1[i]);
                pend_of(i, v);
                chk("R4 random edge", v, ex[i]);
            end
            chk("R10 random irq_ab", {7'b0, irq_ab}, {7'b0, (|ex[0]) | (|ex[1])});
        end

        done = 1'b1;
        report();
    end

endmodule